// File: doc/BRIEF.md
# Serial Port Register Block with Receive Queue

This block is the register side of a serial port. A host reaches it through a simple register bus: a byte offset, a write strobe, a read strobe, 16 bits of write data and 32 bits of read data. Only the low 16 bits of read data carry information. Received bytes enter on a valid/ready byte stream. Bytes written for transmission leave on a one-cycle strobe. A level interrupt tells the host that enough received data is waiting.

The `fifo_mode` strap chooses how received bytes are stored.

- **Queue mode** (`fifo_mode` = 1): bytes go into a 16-entry circular queue. A full flag and an optional interrupt are raised once the queue holds at least a programmable number of bytes.
- **Single mode** (`fifo_mode` = 0): only the latest byte is kept, in a holding register.

Bit-level line coding, baud generation, break detection and error flags belong to the neighbouring line engine and are not part of this block.

**Back-pressure on the receive stream.** `rx_ready` is high exactly while the receive-enable control bit is set. A byte is taken on any cycle where `rx_valid` and `rx_ready` are both high. If the queue is full at that moment, the byte is still taken but then discarded, so a full queue never holds the stream back.

**Transmit output.** The transmit output has no back-pressure. `tx_valid` is high for one cycle and the sink must capture `tx_data` in that cycle.

Top module: `sreg_serial_top`

## Requirements
- R1: The register window covers byte offsets 0x00 to 0x27. The mapped offsets are:
  - 0x00: control
  - 0x04: status
  - 0x08: queue control
  - 0x0c: transmit data
  - 0x10: fill count
  - 0x14: receive data
  - 0x1c: port

  Reads of any other offset return zero, and writes to them change nothing. `bus_rdata[31:16]` is always zero.
- R2: A write to offset 0x0c has three effects:
  - `tx_valid` is high for exactly one cycle after the write edge, with `tx_data` equal to `bus_wdata[7:0]`.
  - The byte is stored and reads back at 0x0c.
  - Status bit 1 (transmit empty) is cleared.
- R3: After reset:
  - control reads 0.
  - status reads 0x0006 (bit 1 transmit empty, bit 2 transmit end, bit 0 clear).
  - fill count, port and queue control read 0.
  - `rx_irq` and `rx_ready` are 0.
- R4: A received byte is accepted only while control bit 4 is set, and `rx_ready` equals that bit. While it is clear, offered bytes leave the fill count unchanged.
- R5: In queue mode each accepted byte is written at the head and the fill count rises by one. The head wraps to entry 0 after entry 15. A byte accepted while the count is 16 is dropped.
- R6: A read of offset 0x14 in queue mode returns the oldest byte, advances the tail with wrap and lowers the count by one. On an empty queue the read returns 0 and changes nothing.
- R7: Status bit 0 (receive full) is set in queue mode whenever the fill count is at or above the trigger level. Writing a status word with bit 0 clear resets this bit. If the count is still at or above the level, the bit sets again on the next cycle.
- R8: A write to offset 0x1c keeps only the bits under mask 0x8f. A read returns the stored value.
- R9: `rx_irq` is high exactly when status bit 0 and control bit 6 are both set.
- R10: Queue control bits [5:4] select the trigger level:

  | Bits [5:4] | Trigger level |
  |---|---|
  | 0 | 1 |
  | 1 | 4 |
  | 2 | 8 |
  | 3 | 14 |

  The selection reads back in the same bits. Writing 1 to bit 0 empties the queue in that cycle, and bit 0 reads as 0.
- R11: In single mode each accepted byte overwrites the holding register. Offset 0x14 returns it without side effect. The fill count reads 0, and status bit 0 is never set by received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| fifo_mode | input | 1 | Strap: 1 selects the receive queue, 0 the single holding register |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the queue at offset 0x14) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receiver enabled; byte taken when valid and ready |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe for a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| rx_irq | output | 1 | Receive interrupt |

## Verification
**Checked on every cycle by assertions:**
- the count stays within bounds.
- the count moves by exactly one on a lone push or pop.
- a full-queue drop leaves the count unchanged.
- a flush empties the queue.
- a byte offered while reception is disabled leaves the count unchanged.
- the transmit strobe and its byte follow each write.
- the port value never holds bits outside its mask.
- the full flag follows the trigger comparison and the clear-by-zero write.

**Shown only by the bench's scenarios:**
- first-in-first-out byte order across a head wrap.
- the drop of a seventeenth byte.
- the mapping from the trigger field to the level.
- the sticky re-setting of the flag after a partial drain.
- the non-destructive read of the single holding register.
- the interrupt gating.
- the reset values.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_QCTL = 6'h08;
  localparam logic [5:0] OFS_TXD  = 6'h0c;
  localparam logic [5:0] OFS_FILL = 6'h10;
  localparam logic [5:0] OFS_RXD  = 6'h14;
  localparam logic [5:0] OFS_PORT = 6'h1c;

  localparam int CTRL_RX_EN  = 4;
  localparam int CTRL_RX_IEN = 6;
  localparam int STAT_FULL   = 0;
  localparam int STAT_TEMPTY = 1;
  localparam int STAT_TEND   = 2;
  localparam int QCTL_FLUSH  = 0;
  localparam int QCTL_TRG_LO = 4;

  localparam logic [7:0] PORT_MASK = 8'h8f;

  typedef enum logic [1:0] {
    TRG_ONE  = 2'd0,
    TRG_QTR  = 2'd1,
    TRG_HALF = 2'd2,
    TRG_HIGH = 2'd3
  } trg_sel_e;
endpackage

// File: rtl/sreg_trig_map.sv
module sreg_trig_map
  import sreg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  trg_sel_e        sel,
  output logic [CW-1:0]   level
);
  always_comb begin
    unique case (sel)
      TRG_ONE:  level = CW'(1);
      TRG_QTR:  level = CW'(DEPTH / 4);
      TRG_HALF: level = CW'(DEPTH / 2);
      default:  level = CW'(DEPTH - 2);
    endcase
  end
endmodule

// File: rtl/sreg_rx_queue.sv
module sreg_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic [DW-1:0] hold_data,
  output logic [CW-1:0] fill
);
  logic [DW-1:0] slots [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop, is_full, is_empty;

  assign is_full  = (fill == CW'(DEPTH));
  assign is_empty = (fill == '0);
  assign do_push  = fifo_mode && push && !is_full && !flush;
  assign do_pop   = fifo_mode && pop && !is_empty && !flush;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 hold_data <= '0;
    else if (!fifo_mode && push) hold_data <= push_data;
  end

  assign head_data = is_empty ? '0 : slots[rd_ptr];

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  p_push_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && push && !pop && !flush && !is_full) |=> fill == $past(fill) + CW'(1));
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && push && !pop && !flush && is_full) |=> fill == CW'(DEPTH));
  p_pop_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && pop && !push && !flush && !is_empty) |=> fill == $past(fill) - CW'(1));
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fill == '0);
  p_hold_latest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && push) |=> hold_data == $past(push_data));
endmodule

// File: rtl/sreg_csr.sv
module sreg_csr
  import sreg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic          wr_qctl,
  input  logic          wr_txd,
  input  logic          wr_port,
  input  logic [15:0]   wdata,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] level,
  output logic [15:0]   ctrl_q,
  output trg_sel_e      trg_sel,
  output logic          flush,
  output logic [7:0]    port_q,
  output logic [7:0]    tx_q,
  output logic          tx_valid,
  output logic          tx_empty,
  output logic          tx_end,
  output logic          rx_full
);
  logic at_trigger, clear_full;

  assign at_trigger = fifo_mode && (fill >= level);
  assign clear_full = wr_stat && !wdata[STAT_FULL];
  assign flush      = wr_qctl && wdata[QCTL_FLUSH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      trg_sel  <= TRG_ONE;
      port_q   <= '0;
      tx_q     <= '0;
      tx_valid <= 1'b0;
      tx_empty <= 1'b1;
      tx_end   <= 1'b1;
      rx_full  <= 1'b0;
    end else begin
      tx_valid <= wr_txd;
      if (wr_ctrl) ctrl_q  <= wdata;
      if (wr_qctl) trg_sel <= trg_sel_e'(wdata[QCTL_TRG_LO +: 2]);
      if (wr_port) port_q  <= wdata[7:0] & PORT_MASK;
      if (wr_txd) begin
        tx_q     <= wdata[7:0];
        tx_empty <= 1'b0;
      end
      if (at_trigger)      rx_full <= 1'b1;
      else if (clear_full) rx_full <= 1'b0;
    end
  end

  p_tx_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> tx_valid && tx_q == $past(wdata[7:0]) && !tx_empty);
  p_tx_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_txd |=> !tx_valid);
  p_port_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q & ~PORT_MASK) == 8'h00);
  p_full_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    at_trigger |=> rx_full);
  p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_full && !at_trigger) |=> !rx_full);
endmodule

// File: rtl/sreg_serial_top.sv
module sreg_serial_top
  import sreg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fifo_mode,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        rx_irq
);
  logic [15:0]   ctrl_q;
  trg_sel_e      trg_sel;
  logic          flush, tx_empty, tx_end, rx_full, push, pop;
  logic [7:0]    port_q, head_data, hold_data;
  logic [CW-1:0] fill, level;
  logic [15:0]   rd_word;

  assign rx_ready = ctrl_q[CTRL_RX_EN];
  assign push     = rx_valid && rx_ready;
  assign pop      = bus_rd && (bus_addr == OFS_RXD);
  assign rx_irq   = rx_full && ctrl_q[CTRL_RX_IEN];

  sreg_trig_map #(.DEPTH(DEPTH)) u_trig (
    .sel   (trg_sel),
    .level (level)
  );

  sreg_csr #(.DEPTH(DEPTH)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .wr_ctrl   (bus_wr && bus_addr == OFS_CTRL),
    .wr_stat   (bus_wr && bus_addr == OFS_STAT),
    .wr_qctl   (bus_wr && bus_addr == OFS_QCTL),
    .wr_txd    (bus_wr && bus_addr == OFS_TXD),
    .wr_port   (bus_wr && bus_addr == OFS_PORT),
    .wdata     (bus_wdata),
    .fill      (fill),
    .level     (level),
    .ctrl_q    (ctrl_q),
    .trg_sel   (trg_sel),
    .flush     (flush),
    .port_q    (port_q),
    .tx_q      (tx_data),
    .tx_valid  (tx_valid),
    .tx_empty  (tx_empty),
    .tx_end    (tx_end),
    .rx_full   (rx_full)
  );

  sreg_rx_queue #(.DEPTH(DEPTH), .DW(8)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .push      (push),
    .push_data (rx_data),
    .pop       (pop),
    .flush     (flush),
    .head_data (head_data),
    .hold_data (hold_data),
    .fill      (fill)
  );

  always_comb begin
    rd_word = '0;
    unique case (bus_addr)
      OFS_CTRL: rd_word = ctrl_q;
      OFS_STAT: rd_word = 16'({tx_end, tx_empty, rx_full});
      OFS_QCTL: rd_word = 16'(trg_sel) << QCTL_TRG_LO;
      OFS_TXD:  rd_word = 16'(tx_data);
      OFS_FILL: rd_word = fifo_mode ? 16'(fill) : 16'h0000;
      OFS_RXD:  rd_word = fifo_mode ? 16'(head_data) : 16'(hold_data);
      OFS_PORT: rd_word = 16'(port_q);
      default:  rd_word = '0;
    endcase
  end

  assign bus_rdata = {16'h0000, rd_word};

  p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && !pop && !flush) |=> $stable(fill));
endmodule

// File: tb/sim_sreg_serial_top.sv
module sim_sreg_serial_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rx_irq;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #4 clk = ~clk;

  sreg_serial_top u0 (
    .clk, .rst_n, .fifo_mode, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .rx_valid, .rx_ready, .rx_data, .tx_valid, .tx_data, .rx_irq
  );

  // {req[3:0], op[1:0], addr[5:0], wdata[15:0], expect[15:0]}
  // op: 0 write, 1 read and compare, 2 offer byte, 3 idle cycle
  localparam int NV = 37;
  localparam logic [43:0] VEC [NV] = '{
    {4'd3, 2'd1, 6'h00, 16'h0000, 16'h0000},  // R3 control
    {4'd3, 2'd1, 6'h04, 16'h0000, 16'h0006},  // R3 status
    {4'd3, 2'd1, 6'h10, 16'h0000, 16'h0000},  // R3 fill
    {4'd3, 2'd1, 6'h1c, 16'h0000, 16'h0000},  // R3 port
    {4'd10,2'd0, 6'h08, 16'h0010, 16'h0000},  // R10 level 4
    {4'd4, 2'd0, 6'h00, 16'h0050, 16'h0000},  // R4 enable + irq enable
    {4'd5, 2'd2, 6'h00, 16'h0011, 16'h0000},  // R5
    {4'd5, 2'd2, 6'h00, 16'h0022, 16'h0000},
    {4'd5, 2'd2, 6'h00, 16'h0033, 16'h0000},
    {4'd5, 2'd1, 6'h10, 16'h0000, 16'h0003},  // R5 count 3
    {4'd7, 2'd1, 6'h04, 16'h0000, 16'h0006},  // R7 below level
    {4'd5, 2'd2, 6'h00, 16'h0044, 16'h0000},
    {4'd7, 2'd3, 6'h00, 16'h0000, 16'h0000},
    {4'd7, 2'd1, 6'h04, 16'h0000, 16'h0007},  // R7 at level
    {4'd6, 2'd1, 6'h14, 16'h0000, 16'h0011},  // R6 oldest first
    {4'd6, 2'd1, 6'h10, 16'h0000, 16'h0003},
    {4'd7, 2'd3, 6'h00, 16'h0000, 16'h0000},
    {4'd7, 2'd1, 6'h04, 16'h0000, 16'h0007},  // R7 flag held
    {4'd7, 2'd0, 6'h04, 16'h0006, 16'h0000},  // R7 clear by zero
    {4'd7, 2'd1, 6'h04, 16'h0000, 16'h0006},
    {4'd8, 2'd0, 6'h1c, 16'hffff, 16'h0000},  // R8
    {4'd8, 2'd1, 6'h1c, 16'h0000, 16'h008f},
    {4'd1, 2'd1, 6'h18, 16'h0000, 16'h0000},  // R1 hole
    {4'd1, 2'd0, 6'h18, 16'hffff, 16'h0000},
    {4'd1, 2'd1, 6'h18, 16'h0000, 16'h0000},
    {4'd2, 2'd0, 6'h0c, 16'h12a5, 16'h0000},  // R2
    {4'd2, 2'd1, 6'h0c, 16'h0000, 16'h00a5},
    {4'd2, 2'd1, 6'h04, 16'h0000, 16'h0004},
    {4'd4, 2'd0, 6'h00, 16'h0040, 16'h0000},  // R4 disable
    {4'd4, 2'd2, 6'h00, 16'h0055, 16'h0000},
    {4'd4, 2'd1, 6'h10, 16'h0000, 16'h0003},
    {4'd6, 2'd1, 6'h14, 16'h0000, 16'h0022},
    {4'd6, 2'd1, 6'h14, 16'h0000, 16'h0033},
    {4'd6, 2'd1, 6'h14, 16'h0000, 16'h0044},
    {4'd6, 2'd1, 6'h14, 16'h0000, 16'h0000},  // R6 empty read
    {4'd6, 2'd1, 6'h10, 16'h0000, 16'h0000},
    {4'd1, 2'd1, 6'h24, 16'h0000, 16'h0000}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, {16'h0000, exp});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic offer(input logic [7:0] b);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        report();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R3 irq", {31'b0, rx_irq}, 0);
    chk("R3 ready", {31'b0, rx_ready}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][43:40], i);
      case (VEC[i][39:38])
        2'd0: do_write(VEC[i][37:32], VEC[i][31:16]);
        2'd1: do_read(VEC[i][37:32], VEC[i][15:0], tag);
        2'd2: offer(VEC[i][23:16]);
        default: @(negedge clk);
      endcase
    end

    // R2 strobe timing
    do_write(6'h0c, 16'h003c);
    chk("R2 tx_valid", {31'b0, tx_valid}, 1);
    chk("R2 tx_data", {24'b0, tx_data}, 32'h3c);
    @(negedge clk);
    chk("R2 one cycle", {31'b0, tx_valid}, 0);

    // R9 interrupt gating, level 1
    do_write(6'h08, 16'h0000);
    do_write(6'h00, 16'h0050);
    chk("R4 ready", {31'b0, rx_ready}, 1);
    offer(8'h77);
    @(negedge clk);
    chk("R9 irq on", {31'b0, rx_irq}, 1);
    do_write(6'h00, 16'h0010);
    chk("R9 irq gated", {31'b0, rx_irq}, 0);
    do_read(6'h04, 16'h0005, "R9 flag kept");
    do_read(6'h14, 16'h0077, "R6");
    do_write(6'h04, 16'h0000);
    do_read(6'h04, 16'h0004, "R7 cleared");

    // R10 level 14, R5 wrap and overflow
    do_write(6'h08, 16'h0030);
    do_read(6'h08, 16'h0030, "R10 readback");
    for (int k = 0; k < 13; k++) offer(8'h80 + 8'(k));
    @(negedge clk);
    do_read(6'h04, 16'h0004, "R10 13 below 14");
    offer(8'h8d);
    @(negedge clk);
    do_read(6'h04, 16'h0005, "R10 14 reaches level");
    offer(8'h8e);
    offer(8'h8f);
    offer(8'hee);
    do_read(6'h10, 16'h0010, "R5 full count");
    for (int k = 0; k < 16; k++) do_read(6'h14, 16'h0080 + 16'(k), "R5 order");
    do_read(6'h10, 16'h0000, "R5 drained");

    // R10 flush
    offer(8'h01); offer(8'h02); offer(8'h03);
    do_write(6'h08, 16'h0031);
    do_read(6'h10, 16'h0000, "R10 flush");
    do_read(6'h14, 16'h0000, "R10 empty after flush");
    do_read(6'h08, 16'h0030, "R10 flush bit reads 0");

    // R11 single mode
    do_write(6'h04, 16'h0000);
    fifo_mode = 1'b0;
    offer(8'h12);
    offer(8'h34);
    do_read(6'h14, 16'h0034, "R11 latest");
    do_read(6'h14, 16'h0034, "R11 non-destructive");
    do_read(6'h10, 16'h0000, "R11 fill");
    do_read(6'h04, 16'h0004, "R11 no full flag");

    // R3 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    fifo_mode = 1'b1;
    do_read(6'h04, 16'h0006, "R3 status after reset");
    do_read(6'h10, 16'h0000, "R3 fill after reset");
    chk("R3 ready after reset", {31'b0, rx_ready}, 0);
    chk("R3 irq after reset", {31'b0, rx_irq}, 0);
    rst_n = 1'b1;
    report();
  end
endmodule